// File: doc/BRIEF.md
# Counter and Dual-Period PWM Timer Channel

This block is one timer channel with two ways of driving its output pin. In counter mode it counts timer ticks up to a 32-bit target. On each completion it raises an event and changes the pin according to a programmable action. It then either starts again from zero or stops, depending on the loop setting. In PWM mode the same target word is split into two 16-bit phase lengths, and the pin alternates between them. The first phase is driven at a programmed starting level and the second at the opposite level.

Events feed a small interrupt unit. The unit has an enable bit, a mask bit, raw and masked pending status, and an overflow flag. The overflow flag records a second event that arrives before software has acknowledged the first one. Software acknowledges by reading the count register. Configuration and status pass through a plain synchronous register port. A tick input qualifies every counting step, so the channel can run from any divided timebase.

Top module: `pwm_count_timer`

## Requirements
- R1: In counter mode (CTRL bit1 = 0), with tick high on every cycle, the first completion happens on the (target+1)-th tick after enable. It sets the raw pending bit (STATUS bit0).
- R2: CTRL bits [4:3] choose the pin action on a counter completion: 0 leaves the pin unchanged, 1 inverts it, 2 drives it high, 3 drives it low.
- R3: With CTRL bit2 = 1 (loop) the counter restarts from zero after each completion. With bit2 = 0 it stops after the first completion, holds the count at the target, and raises no further events.
- R4: In PWM mode (CTRL bit1 = 1), TARGET bits [15:0] give the length of phase 0 in ticks and bits [31:16] give the length of phase 1.
- R5: In PWM mode the pin is at the starting level (CTRL bit5) during phase 0 and at the inverse level during phase 1.
- R6: In PWM mode every pin level change is an event. STATUS bit3 reports the phase that is currently active.
- R7: A read of the COUNT register (address 3) returns the count and clears the raw pending bit and the overflow flag. Read data appears on rdData, with rdValid high, in the cycle after rdEn.
- R8: An event that arrives while the raw pending bit is already set sets the overflow flag (STATUS bit2).
- R9: While CTRL bit0 (enable) is 0, the count is held at zero and the pin at the starting level. Setting the bit starts counting from zero.
- R10: STATUS bit1 is raw pending AND NOT mask (INTCTL bit1). irq is high only when raw is pending, INTCTL bit0 (enable) is 1 and the mask is 0.
- R11: A PWM phase length of zero lasts one tick.
- R12: After reset all registers are zero, the pin is low and irq is low. The address map is: CTRL 0, TARGET 1, INTCTL 2, COUNT 3, STATUS 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable; one counting step per high cycle |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| rdValid | output | 1 | rdData is valid this cycle |
| pinOut | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the off-by-one at the target value. A design that completes on the target-th tick instead of the (target+1)-th moves the pin one cycle early, and the pin checks catch it. Overflow is built up by letting two loop completions pass without a count read. A design that set overflow on the first event, or failed to clear it on the read, shows the wrong STATUS word. Single mode is checked to hold at the target: a design that kept looping would show a fresh pending bit after the acknowledge. PWM is run with unequal phase lengths and with both lengths at zero. Swapped halves, a wrong level per phase, or a stall on a zero length would each show up in the cycle-exact pin samples.

// File: rtl/timer_pkg.sv
package timer_pkg;
  parameter int TGT_W  = 32;
  parameter int HALF_W = TGT_W / 2;
  parameter int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_TARGET = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_INTCTL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd4;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_INVERT = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_LOW    = 2'd3
  } pinAction_e;

  // Configuration strobes handed from control to datapath
  typedef struct packed {
    logic             enable;
    logic             pwmMode;
    logic             loopMode;
    pinAction_e       action;
    logic             initLevel;
    logic [TGT_W-1:0] target;
  } dpCfg_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  dpCfg_t           cfg,
  output logic             evt,
  output logic [TGT_W-1:0] count,
  output logic             phase,
  output logic             pinOut
);
  logic              done;
  logic [HALF_W-1:0] curLen;
  logic [HALF_W-1:0] lastIdx;
  logic              pwmWrap;
  logic              cntHit;
  logic              actLevel;

  assign curLen  = phase ? cfg.target[TGT_W-1:HALF_W] : cfg.target[HALF_W-1:0];
  assign lastIdx = (curLen == '0) ? '0 : curLen - 1'b1;
  assign pwmWrap = count >= {{(TGT_W-HALF_W){1'b0}}, lastIdx};
  assign cntHit  = !done && (count >= cfg.target);
  assign evt     = cfg.enable && tick && (cfg.pwmMode ? pwmWrap : cntHit);

  always_comb begin
    unique case (cfg.action)
      ACT_KEEP:   actLevel = pinOut;
      ACT_INVERT: actLevel = ~pinOut;
      ACT_HIGH:   actLevel = 1'b1;
      default:    actLevel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      phase  <= 1'b0;
      done   <= 1'b0;
      pinOut <= 1'b0;
    end else if (!cfg.enable) begin
      count  <= '0;
      phase  <= 1'b0;
      done   <= 1'b0;
      pinOut <= cfg.initLevel;
    end else if (tick) begin
      if (cfg.pwmMode) begin
        done <= 1'b0;
        if (pwmWrap) begin
          count  <= '0;
          phase  <= ~phase;
          pinOut <= phase ? cfg.initLevel : ~cfg.initLevel;
        end else begin
          count  <= count + 1'b1;
          pinOut <= phase ? ~cfg.initLevel : cfg.initLevel;
        end
      end else if (cntHit) begin
        pinOut <= actLevel;
        if (cfg.loopMode) count <= '0;
        else              done  <= 1'b1;
      end else if (!done) begin
        count <= count + 1'b1;
      end
    end
  end

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> (count == '0) && (phase == 1'b0) && (pinOut == $past(cfg.initLevel))); // R9

  AST_PWM_PHASE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (evt && cfg.pwmMode) |=> (phase != $past(phase))); // R6

  AST_SINGLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (evt && !cfg.pwmMode && !cfg.loopMode && cfg.enable) |=> (count == $past(count)) || !$past(cfg.enable)); // R3
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TGT_W-1:0]  wrData,
  input  logic              evt,
  input  logic [TGT_W-1:0]  count,
  input  logic              phase,
  output dpCfg_t            cfg,
  output logic [TGT_W-1:0]  rdData,
  output logic              rdValid,
  output logic              irq
);
  logic             enReg, pwmReg, loopReg, initReg;
  pinAction_e       actReg;
  logic [TGT_W-1:0] targetReg;
  logic             intEn, intMask;
  logic             rawPend, ovfFlag;
  logic             clrPend;
  logic             maskedPend;
  logic [TGT_W-1:0] readMux;

  assign cfg = '{enable: enReg, pwmMode: pwmReg, loopMode: loopReg,
                 action: actReg, initLevel: initReg, target: targetReg};

  assign clrPend    = rdEn && (addr == ADR_COUNT);
  assign maskedPend = rawPend && !intMask;
  assign irq        = maskedPend && intEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      pwmReg    <= 1'b0;
      loopReg   <= 1'b0;
      actReg    <= ACT_KEEP;
      initReg   <= 1'b0;
      targetReg <= '0;
      intEn     <= 1'b0;
      intMask   <= 1'b0;
    end else if (wrEn) begin
      unique case (addr)
        ADR_CTRL: begin
          enReg   <= wrData[0];
          pwmReg  <= wrData[1];
          loopReg <= wrData[2];
          actReg  <= pinAction_e'(wrData[4:3]);
          initReg <= wrData[5];
        end
        ADR_TARGET: targetReg <= wrData;
        ADR_INTCTL: begin
          intEn   <= wrData[0];
          intMask <= wrData[1];
        end
        default: ;
      endcase
    end
  end

  // Pending and overflow: a same-cycle event beats the clearing read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawPend <= 1'b0;
      ovfFlag <= 1'b0;
    end else if (evt) begin
      rawPend <= 1'b1;
      if (clrPend)      ovfFlag <= 1'b0;
      else if (rawPend) ovfFlag <= 1'b1;
    end else if (clrPend) begin
      rawPend <= 1'b0;
      ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    readMux = '0;
    unique case (addr)
      ADR_CTRL:   readMux = {{(TGT_W-6){1'b0}}, initReg, actReg, loopReg, pwmReg, enReg};
      ADR_TARGET: readMux = targetReg;
      ADR_INTCTL: readMux = {{(TGT_W-2){1'b0}}, intMask, intEn};
      ADR_COUNT:  readMux = count;
      ADR_STATUS: readMux = {{(TGT_W-4){1'b0}}, phase, ovfFlag, maskedPend, rawPend};
      default:    readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= readMux;
    end
  end

  AST_OVF_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(rawPend)); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (clrPend && !evt) |=> !rawPend && !ovfFlag); // R7

  AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    evt |=> rawPend); // R1

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rawPend && intEn); // R10
endmodule

// File: rtl/pwm_count_timer.sv
module pwm_count_timer
  import timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        pinOut,
  output logic        irq
);
  dpCfg_t           cfgBus;
  logic             evtStb;
  logic [TGT_W-1:0] countVal;
  logic             phaseVal;

  timer_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrData (wrData),
    .evt    (evtStb),
    .count  (countVal),
    .phase  (phaseVal),
    .cfg    (cfgBus),
    .rdData (rdData),
    .rdValid(rdValid),
    .irq    (irq)
  );

  timer_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .cfg    (cfgBus),
    .evt    (evtStb),
    .count  (countVal),
    .phase  (phaseVal),
    .pinOut (pinOut)
  );
endmodule

// File: tb/pwm_count_timer_bench.sv
`timescale 1ns/1ps
module pwm_count_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        pinOut;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  pwm_count_timer u_pwm_count_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .pinOut(pinOut), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Driver side of the scoreboard: issue a read and queue its expectation
  task automatic regRead(input logic [2:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side: pop and compare each returned read
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 read with no expectation actual=%0h expected=none", rdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, rdData, e);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(1);
    // R12 reset state
    check("R12 pin after reset", pinOut, 0);
    check("R12 irq after reset", irq, 0);
    regRead(3'd4, 32'h0, "R12 status after reset");
    regRead(3'd0, 32'h0, "R12 ctrl after reset");

    // Counter, loop, invert, target 4
    regWrite(3'd1, 32'd4);
    regWrite(3'd2, 32'h1);
    regWrite(3'd0, 32'd13);
    waitN(4);
    check("R1 pin before target+1 ticks", pinOut, 0);
    waitN(1);
    check("R2 invert on completion", pinOut, 1);
    check("R1 irq on completion", irq, 1);
    waitN(5);
    check("R3 loop second completion", pinOut, 0);
    regRead(3'd4, 32'h7, "R8 overflow after two events");
    regRead(3'd3, 32'd1, "R7 count value on read");
    regRead(3'd4, 32'h0, "R7 pending cleared by count read");
    check("R7 irq cleared", irq, 0);
    regWrite(3'd0, 32'd0);
    waitN(10);
    regRead(3'd3, 32'd0, "R9 count held at zero while disabled");
    regRead(3'd4, 32'h0, "R9 no events while disabled");

    // Single, drive high, target 2
    regWrite(3'd1, 32'd2);
    regWrite(3'd0, 32'd17);
    waitN(2);
    check("R2 drive-high not yet", pinOut, 0);
    waitN(1);
    check("R2 drive high", pinOut, 1);
    waitN(8);
    regRead(3'd3, 32'd2, "R3 single holds at target");
    regRead(3'd4, 32'h0, "R3 single pending cleared");
    waitN(6);
    regRead(3'd4, 32'h0, "R3 single raises no further event");

    // Disabled, start level high; then loop drive low
    regWrite(3'd0, 32'd32);
    waitN(1);
    check("R9 pin at start level while disabled", pinOut, 1);
    regWrite(3'd0, 32'd61);
    waitN(2);
    check("R2 drive-low not yet", pinOut, 1);
    waitN(1);
    check("R2 drive low", pinOut, 0);

    // Keep action, loop, target 1
    regWrite(3'd0, 32'd0);
    waitN(1);
    regRead(3'd3, 32'd0, "R7 clear before keep test");
    regWrite(3'd1, 32'd1);
    regWrite(3'd0, 32'd5);
    waitN(10);
    check("R2 keep leaves pin", pinOut, 0);
    regRead(3'd4, 32'h7, "R10 raw masked overflow set");
    regWrite(3'd2, 32'h3);
    waitN(1);
    check("R10 irq blocked by mask", irq, 0);
    regRead(3'd4, 32'h5, "R10 masked status cleared by mask");
    regWrite(3'd2, 32'h0);
    regRead(3'd4, 32'h7, "R10 masked status with enable off");
    check("R10 irq blocked by enable off", irq, 0);
    regWrite(3'd2, 32'h1);
    check("R10 irq when enabled and unmasked", irq, 1);

    // PWM, phase0=2 phase1=3, start level high
    regWrite(3'd0, 32'd32);
    waitN(1);
    regRead(3'd3, 32'd0, "R7 clear before pwm");
    regWrite(3'd1, 32'h0003_0002);
    regWrite(3'd0, 32'd35);
    check("R5 phase0 at start level", pinOut, 1);
    waitN(1);
    check("R4 phase0 second tick", pinOut, 1);
    waitN(1);
    check("R5 phase1 inverse level", pinOut, 0);
    check("R6 irq on level change", irq, 1);
    regRead(3'd4, 32'hB, "R6 active phase bit");
    waitN(1);
    check("R4 phase1 third tick", pinOut, 0);
    waitN(1);
    check("R4 back to phase0 after 3 ticks", pinOut, 1);

    // PWM with zero lengths
    regWrite(3'd0, 32'd0);
    waitN(1);
    regWrite(3'd1, 32'h0);
    regWrite(3'd0, 32'd3);
    check("R11 start low", pinOut, 0);
    waitN(1);
    check("R11 zero length one tick a", pinOut, 1);
    waitN(1);
    check("R11 zero length one tick b", pinOut, 0);
    waitN(1);
    check("R11 zero length one tick c", pinOut, 1);

    waitN(3);
    finish();
  end
endmodule